// File: doc/BRIEF.md
# Posted Write Clock-Crossing Bridge

This block lets a fast register bus update a bank of registers clocked by a slow timer clock without stalling. A write is captured on the fast side into a per-register holding register. A request toggle then carries it across to the slow domain. The slow domain copies the held value into its own register and returns an acknowledge toggle. While this exchange runs, the register's pending flag is set, and software can poll it.

Three sticky status sources sit on the fast side:

- A "posted" event, set whenever a write is accepted.
- A "done" event, set when a pending flag drops and the new value has landed.
- An "error" event, set when software writes to a register whose previous write is still in flight. The offending write is discarded, and the value already in flight is delivered untouched.

Each source reaches the single interrupt output only through its own enable bit. Status bits are cleared by writing ones to them.

Top module: `pw_sync_bridge`

## Requirements
- R1: After reset, all pending flags, all status bits, all enable bits and the interrupt are 0, and every slow register holds RST_VAL.
- R2: A write with `wr_en` high to a register whose pending flag is 0 is accepted. The flag `pending[wr_addr]` reads 1 from the following fast cycle and stays 1 until the slow copy has been updated.
- R3: After an accepted write, the slow register `slow_bus[a*DW +: DW]` holds the written data once `pending[a]` has returned to 0, within a bounded number of cycles.
- R4: A write to a register whose pending flag is 1 is dropped and sets status bit 1 (error) in the following cycle. The slow register still receives the value that was already in flight.
- R5: Status bit 2 (posted) is set in the cycle after every accepted write.
- R6: Status bit 0 (done) is set no later than two fast cycles after a pending flag falls.
- R7: A status bit falls only when `clr_wr` is high with the matching bit of `clr_data` at 1; bits written 0 are kept. When a set event and a clear of the same bit coincide, the bit stays 1.
- R8: `irq` is the OR, over bit i, of `status[i]` AND `irq_en[i]`. `irq_en` is loaded from `en_data` when `en_wr` is high and resets to 0.
- R9: Registers are independent. A write to one register changes neither the pending flag nor the slow value of another, and writes to distinct registers in consecutive cycles are all accepted and delivered without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_f | input | 1 | Fast register-bus clock |
| rst_f_n | input | 1 | Fast-domain asynchronous reset, active low |
| clk_s | input | 1 | Slow timer clock |
| rst_s_n | input | 1 | Slow-domain asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Index of the slow register being written |
| wr_data | input | DW | Write data |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 3 | Ones clear the matching status bits |
| en_wr | input | 1 | Interrupt enable load strobe |
| en_data | input | 3 | New interrupt enable bits |
| pending | output | NREG | Per-register write-in-flight flags |
| status | output | 3 | Sticky status: bit0 done, bit1 error, bit2 posted |
| irq_en | output | 3 | Current interrupt enables |
| irq | output | 1 | Interrupt request |
| slow_bus | output | NREG*DW | Slow-domain register values, register k at bits k*DW +: DW |

## Verification
The checker watches every fast cycle for the following:

- A pending flag rising after each accepted write.
- The holding register staying frozen while its flag is set.
- The error bit following any write to a busy register.
- Status bits falling only under a matching clear.
- The interrupt staying low whenever no enabled source is set.

Whether the value actually lands in the slow register, the completion latency, the dropping of a rejected write's data, set-over-clear priority and every combination of status and enable only show up in the bench's scenarios, which compare against a model of expected register contents.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int NSRC = 3;

  typedef enum int {
    SRC_DONE = 0,
    SRC_ERR  = 1,
    SRC_POST = 2
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;

  // Sticky update: a set event dominates a concurrent clear.
  function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t set_v, src_vec_t clr_v);
    return set_v | (cur & ~clr_v);
  endfunction

  // Interrupt reduction over enabled sources.
  function automatic logic irq_of(src_vec_t st, src_vec_t en);
    return |(st & en);
  endfunction

  // Pending state of a toggle handshake lane.
  function automatic logic lane_busy(logic req_t, logic ack_seen);
    return req_t ^ ack_seen;
  endfunction
endpackage

// File: rtl/pw_sync2.sv
module pw_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/pw_lane.sv
module pw_lane
  import pw_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          SYNC    = 2,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk_f,
  input  logic          rst_f_n,
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic          accept,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          done_pulse,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] slow_q
);
  // Fast side: request toggle and frozen holding register.
  logic req_t;
  logic ack_f;
  logic ack_d;

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      req_t  <= 1'b0;
      hold_q <= RST_VAL;
      ack_d  <= 1'b0;
    end else begin
      ack_d <= ack_f;
      if (accept) begin
        req_t  <= ~req_t;
        hold_q <= din;
      end
    end
  end

  assign busy       = lane_busy(req_t, ack_f);
  assign done_pulse = ack_d ^ ack_f;

  // Slow side: detect request edge, copy held data, echo acknowledge.
  logic req_s;
  logic req_sd;
  logic ack_t;
  logic req_edge;

  pw_sync2 #(.STAGES(SYNC)) u_req_sync (
    .clk   (clk_s),
    .rst_n (rst_s_n),
    .d     (req_t),
    .q     (req_s)
  );

  assign req_edge = req_s ^ req_sd;

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_sd <= 1'b0;
      ack_t  <= 1'b0;
      slow_q <= RST_VAL;
    end else begin
      req_sd <= req_s;
      if (req_edge) begin
        slow_q <= hold_q;
        ack_t  <= req_s;
      end
    end
  end

  pw_sync2 #(.STAGES(SYNC)) u_ack_sync (
    .clk   (clk_f),
    .rst_n (rst_f_n),
    .d     (ack_t),
    .q     (ack_f)
  );
endmodule

// File: rtl/pw_status.sv
module pw_status
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     clr_wr,
  input  src_vec_t clr_data,
  input  logic     en_wr,
  input  src_vec_t en_data,
  output src_vec_t status,
  output src_vec_t en_q,
  output logic     irq
);
  src_vec_t clr_eff;

  assign clr_eff = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      en_q   <= '0;
    end else begin
      status <= sticky_next(status, set_vec, clr_eff);
      if (en_wr) en_q <= en_data;
    end
  end

  assign irq = irq_of(status, en_q);
endmodule

// File: rtl/pw_sync_bridge.sv
module pw_sync_bridge
  import pw_pkg::*;
#(
  parameter int            NREG    = 4,
  parameter int            DW      = 16,
  parameter int            SYNC    = 2,
  parameter logic [DW-1:0] RST_VAL = '0,
  localparam int           AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk_f,
  input  logic               rst_f_n,
  input  logic               clk_s,
  input  logic               rst_s_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               clr_wr,
  input  logic [2:0]         clr_data,
  input  logic               en_wr,
  input  logic [2:0]         en_data,
  output logic [NREG-1:0]    pending,
  output logic [2:0]         status,
  output logic [2:0]         irq_en,
  output logic               irq,
  output logic [NREG*DW-1:0] slow_bus
);
  logic [NREG-1:0]    sel;
  logic [NREG-1:0]    accept;
  logic [NREG-1:0]    done_pulse;
  logic [NREG*DW-1:0] hold_bus;
  logic               err_evt;
  logic               post_evt;
  logic               done_evt;
  src_vec_t           set_vec;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++) sel[i] = (32'(wr_addr) == i);
  end

  assign accept   = wr_en ? (sel & ~pending) : '0;
  assign err_evt  = wr_en & (|(sel & pending));
  assign post_evt = |accept;
  assign done_evt = |done_pulse;

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_DONE] = done_evt;
    set_vec[SRC_ERR]  = err_evt;
    set_vec[SRC_POST] = post_evt;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_lane
    pw_lane #(.DW(DW), .SYNC(SYNC), .RST_VAL(RST_VAL)) u_lane (
      .clk_f      (clk_f),
      .rst_f_n    (rst_f_n),
      .clk_s      (clk_s),
      .rst_s_n    (rst_s_n),
      .accept     (accept[k]),
      .din        (wr_data),
      .busy       (pending[k]),
      .done_pulse (done_pulse[k]),
      .hold_q     (hold_bus[k*DW +: DW]),
      .slow_q     (slow_bus[k*DW +: DW])
    );
  end

  pw_status u_status (
    .clk      (clk_f),
    .rst_n    (rst_f_n),
    .set_vec  (set_vec),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .en_wr    (en_wr),
    .en_data  (en_data),
    .status   (status),
    .en_q     (irq_en),
    .irq      (irq)
  );
endmodule

// File: rtl/pw_sync_bridge_chk.sv
module pw_sync_bridge_chk #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input logic               clk_f,
  input logic               rst_f_n,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic               clr_wr,
  input logic [2:0]         clr_data,
  input logic [NREG-1:0]    pending,
  input logic [2:0]         status,
  input logic [2:0]         irq_en,
  input logic               irq,
  input logic [NREG*DW-1:0] hold_bus
);
  logic in_range;
  logic tgt_busy;

  assign in_range = 32'(wr_addr) < NREG;
  assign tgt_busy = in_range && pending[wr_addr];

  // R2: accepted write raises its pending flag next cycle
  a_r2_pend_rise: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (wr_en && in_range && !tgt_busy) |=> pending[$past(wr_addr)]);

  // R4: write to a busy register flags an error
  a_r4_err_flag: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (wr_en && tgt_busy) |=> status[1]);

  // R5: accepted write sets the posted bit
  a_r5_post_flag: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (wr_en && in_range && !tgt_busy) |=> status[2]);

  // R8: no interrupt without an enabled source
  a_r8_irq_masked: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    ((status & irq_en) == 3'b000) |-> !irq);

  for (genvar i = 0; i < 3; i++) begin : g_st
    // R7: sticky bit falls only under a matching clear
    a_r7_sticky_hold: assert property (@(posedge clk_f) disable iff (!rst_f_n)
      $fell(status[i]) |-> $past(clr_wr && clr_data[i]));
  end

  for (genvar k = 0; k < NREG; k++) begin : g_hold
    // R4: in-flight value stays frozen while pending
    a_r4_hold_frozen: assert property (@(posedge clk_f) disable iff (!rst_f_n)
      (pending[k] && $past(pending[k])) |-> $stable(hold_bus[k*DW +: DW]));
  end
endmodule

bind pw_sync_bridge pw_sync_bridge_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk_f    (clk_f),
  .rst_f_n  (rst_f_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .clr_wr   (clr_wr),
  .clr_data (clr_data),
  .pending  (pending),
  .status   (status),
  .irq_en   (irq_en),
  .irq      (irq),
  .hold_bus (hold_bus)
);

// File: tb/sim_pw_sync_bridge.sv
`timescale 1ns/1ps
module sim_pw_sync_bridge;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 2;

  logic clk_f = 1'b0;
  logic clk_s = 1'b0;
  logic rst_f_n, rst_s_n;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic clr_wr;
  logic [2:0] clr_data;
  logic en_wr;
  logic [2:0] en_data;
  logic [NREG-1:0] pending;
  logic [2:0] status;
  logic [2:0] irq_en;
  logic irq;
  logic [NREG*DW-1:0] slow_bus;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  always #2.5 clk_f = ~clk_f;
  always #37  clk_s = ~clk_s;

  pw_sync_bridge #(.NREG(NREG), .DW(DW)) u0 (
    .clk_f(clk_f), .rst_f_n(rst_f_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_wr(clr_wr), .clr_data(clr_data), .en_wr(en_wr), .en_data(en_data),
    .pending(pending), .status(status), .irq_en(irq_en), .irq(irq),
    .slow_bus(slow_bus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk_f);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk_f);
    wr_en = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk_f);
    clr_wr = 1'b1; clr_data = m;
    @(negedge clk_f);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic set_en(input logic [2:0] m);
    @(negedge clk_f);
    en_wr = 1'b1; en_data = m;
    @(negedge clk_f);
    en_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (pending !== '0 && n < 400) begin
      @(negedge clk_f);
      n++;
    end
    check(req, 32'(n < 400), 32'd1);
    repeat (2) @(negedge clk_f);
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++)
      check(req, 32'(slow_bus[k*DW +: DW]), 32'(model[k]));
  endtask

  function automatic logic [DW-1:0] pat(input int k, input int p);
    case (p)
      0: return '0;
      1: return '1;
      2: return DW'(16'hA5A5 ^ k);
      default: return DW'((k + 1) * 16'h1111 + p);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_f);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_f_n = 1'b0; rst_s_n = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    clr_wr = 1'b0; clr_data = '0; en_wr = 1'b0; en_data = '0;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (4) @(posedge clk_s);
    @(negedge clk_f);
    rst_f_n = 1'b1; rst_s_n = 1'b1;
    @(negedge clk_f);

    // R1: reset state
    check("R1 pending", 32'(pending), 32'd0);
    check("R1 status", 32'(status), 32'd0);
    check("R1 irq_en", 32'(irq_en), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check_regs("R1 slow regs");

    // R2 R3 R9: sweep registers and data patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < NREG; k++) begin
        wr(k, pat(k, p));
        model[k] = pat(k, p);
        check("R2 pending set", 32'(pending), 32'(1 << k));
        wait_idle("R3 completes");
        check_regs("R3 R9 values");
        check("R3 no error", 32'(status[1]), 32'd0);
      end
    end

    // R5 R6: posted and done bits
    clr(3'b111);
    check("R7 cleared", 32'(status), 32'd0);
    wr(2, 16'h1234); model[2] = 16'h1234;
    check("R5 posted", 32'(status), 32'b100);
    wait_idle("R3 completes");
    check("R6 done", 32'(status), 32'b101);

    // R4: write to busy register dropped, in-flight value delivered
    clr(3'b111);
    wr(1, 16'hBEEF); model[1] = 16'hBEEF;
    wr(1, 16'hDEAD);
    check("R4 error flag", 32'(status[1]), 32'd1);
    check("R4 still pending", 32'(pending[1]), 32'd1);
    wait_idle("R4 completes");
    check_regs("R4 in-flight value kept");

    // R9: back-to-back writes to distinct registers
    clr(3'b111);
    @(negedge clk_f);
    for (int k = 0; k < NREG; k++) begin
      wr_en = 1'b1; wr_addr = AW'(k); wr_data = pat(k, 5); model[k] = pat(k, 5);
      @(negedge clk_f);
    end
    wr_en = 1'b0;
    check("R9 all pending", 32'(pending), 32'((1 << NREG) - 1));
    check("R9 no error", 32'(status[1]), 32'd0);
    wait_idle("R9 completes");
    check_regs("R9 values");

    // R7: partial clear and set-over-clear
    wr(0, 16'h0F0F); model[0] = 16'h0F0F;
    wr(0, 16'hF0F0);
    wait_idle("R7 setup");
    check("R7 all set", 32'(status), 32'b111);
    clr(3'b010);
    check("R7 partial clear", 32'(status), 32'b101);
    @(negedge clk_f);
    wr_en = 1'b1; wr_addr = AW'(3); wr_data = 16'h5555; model[3] = 16'h5555;
    clr_wr = 1'b1; clr_data = 3'b100;
    @(negedge clk_f);
    wr_en = 1'b0; clr_wr = 1'b0; clr_data = '0;
    check("R7 set wins", 32'(status[2]), 32'd1);
    wait_idle("R7 completes");
    check_regs("R7 values");

    // R8: every status pattern against every enable mask
    for (int m = 0; m < 8; m++) begin
      for (int keep = 0; keep < 8; keep++) begin
        set_en(3'(m));
        check("R8 enable readback", 32'(irq_en), 32'(m));
        wr(0, DW'(m * 8 + keep)); model[0] = DW'(m * 8 + keep);
        wr(0, 16'hFFFF);
        wait_idle("R8 setup");
        clr(3'(~keep));
        check("R8 status", 32'(status), 32'(keep));
        check("R8 irq", 32'(irq), 32'((m & keep) != 0));
      end
    end
    check_regs("R8 values");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule